// File: doc/BRIEF.md
# Chip-Select Window Address Decoder

This block maps a 32-bit bus address onto one of eight programmable chip-select windows. Each window is set up by a 12-bit configuration word: an enable bit, a 6-bit base that places the window on a 16 MB grid, and a 4-bit size mask. Software writes a word into one slot through a simple write port. From then on, every request strobe is compared against all of the enabled windows.

A window is used only if its configuration is legal. The size mask must take one of four encodings, which give windows of 16, 32, 64 or 128 MB. The base must also be aligned to the chosen size. An enabled window that fails either check is not truncated or adjusted. It stays out of decoding and raises its illegal-configuration flag.

One cycle after the request strobe, the decoder returns three results for that cycle only: a one-hot chip-select vector, a hit flag, and the address offset relative to the start of the selected window. If several windows match, the lowest-numbered one wins.

Top module: `cs_window_decoder`

## Requirements
- R1: Configuration word fields are as follows. Bit 6 is the enable. Bits 5:0 are the base. Bits 11:8 are the mask. Bit 7 is not stored and has no effect on decoding.
- R2: Only the mask values 4'b1000, 4'b1100, 4'b1110 and 4'b1111 are legal. An enabled window with any other mask never asserts its chip-select.
- R3: An enabled window whose base bits 3:0 AND the inverted mask are non-zero is rejected and never asserts its chip-select.
- R4: A legal window starts at base<<24. It covers 128, 64, 32 or 16 MB for masks 4'b1000, 4'b1100, 4'b1110 and 4'b1111. Addresses outside this range do not select it.
- R5: After reset, slot 0 holds enable=1, base=0 and mask=4'b1111, so it covers 0x00000000 to 0x00FFFFFF. All other slots are disabled, and all outputs are low.
- R6: A configuration write takes effect from the next cycle onward. The old window of that slot no longer decodes, and the new value is decoded in its place. Writing a zero word disables the slot.
- R7: When several legal windows match one address, only the lowest-numbered chip-select is asserted.
- R8: A request registered on a clock edge drives cs_o, hit_o and offset_o during the following cycle only. Without a request, all three outputs are zero.
- R9: On a hit, offset_o equals the address minus the window start, masked to the window size. On a miss, offset_o is zero.
- R10: bad_cfg_o[i] is high for as long as slot i is enabled but fails the check of R2 or R3. Otherwise it is low.
- R11: cs_o is all zero or one-hot, and hit_o is high exactly when cs_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Slot index for the configuration write |
| cfg_wdata_i | input | 12 | Configuration word written |
| req_i | input | 1 | Request strobe |
| addr_i | input | 32 | Request address |
| cs_o | output | 8 | One-hot chip-select, one cycle after the request |
| hit_o | output | 1 | Request matched a legal window |
| offset_o | output | 32 | Window-relative offset |
| bad_cfg_o | output | 8 | Per-slot illegal-configuration flag |

## Verification
The in-line assertions check four properties on every cycle: the one-hot form of cs_o, the agreement between hit_o and cs_o, the absence of any output without a preceding request, and that no slot flagged illegal is ever selected. Properties that depend on values can only be shown by the bench scenarios. These include the window start and size for each mask, the offset arithmetic, priority among overlapping windows, the reset map, the ignored bit 7 and the removal of a window after reconfiguration. The bench compares the outputs against its own model of the slot table.

// File: rtl/cswd_pkg.sv
package cswd_pkg;
  localparam int BASE_W = 6;
  localparam int MASK_W = 4;
  localparam int CFG_W  = 12;
  localparam int EN_BIT = 6;
  localparam int MASK_LSB = 8;
  localparam int WIN_SHIFT = 24;
  localparam logic [CFG_W-1:0] CFG_KEEP = 12'hF7F;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [MASK_W-1:0] mask;
  } win_t;

  function automatic logic mask_ok(input logic [MASK_W-1:0] m);
    return (m == 4'b1000) || (m == 4'b1100) || (m == 4'b1110) || (m == 4'b1111);
  endfunction
endpackage

// File: rtl/cswd_slot.sv
module cswd_slot
  import cswd_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output win_t             win_o,
  output logic             bad_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= RST_CFG;
    else if (we_i) cfg_q <= wdata_i & CFG_KEEP;
  end

  wire              vld  = cfg_q[EN_BIT];
  wire [BASE_W-1:0] base = cfg_q[BASE_W-1:0];
  wire [MASK_W-1:0] mask = cfg_q[MASK_LSB +: MASK_W];

  // base fits in BASE_W bits by construction; alignment and mask shape checked here
  assign legal = mask_ok(mask) && ((base[MASK_W-1:0] & ~mask) == '0);

  assign win_o.en   = vld && legal;
  assign win_o.base = base;
  assign win_o.mask = mask;
  assign bad_o      = vld && !legal;

  a_r10_bad_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bad_o && win_o.en));
endmodule

// File: rtl/cswd_match.sv
module cswd_match
  import cswd_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 32
) (
  input  win_t [NUM_CS-1:0] win_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CS-1:0] sel_o,
  output logic [ADDR_W-1:0] offset_o
);
  localparam int HI_W = ADDR_W - WIN_SHIFT;

  logic [NUM_CS-1:0] match;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    wire [HI_W-1:0] hmask = {{(HI_W-MASK_W){1'b1}}, win_i[i].mask};
    assign match[i] = win_i[i].en &&
      ((addr_i[ADDR_W-1:WIN_SHIFT] & hmask) == HI_W'(win_i[i].base));
  end

  always_comb begin
    sel_o    = '0;
    offset_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_o    = '0;
        sel_o[i] = 1'b1;
        offset_o = '0;
        offset_o[WIN_SHIFT+MASK_W-1:0] = addr_i[WIN_SHIFT+MASK_W-1:0] &
                                         {~win_i[i].mask, {WIN_SHIFT{1'b1}}};
      end
    end
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cswd_pkg::*;
#(
  parameter  int NUM_CS = 8,
  parameter  int ADDR_W = 32,
  localparam int SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic [NUM_CS-1:0] bad_cfg_o
);
  localparam logic [CFG_W-1:0] CS0_RST = 12'hF40;

  win_t [NUM_CS-1:0] win;
  logic [NUM_CS-1:0] sel_d;
  logic [ADDR_W-1:0] off_d;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
    cswd_slot #(.RST_CFG(i == 0 ? CS0_RST : '0)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i && (cfg_sel_i == SEL_W'(i))),
      .wdata_i (cfg_wdata_i),
      .win_o   (win[i]),
      .bad_o   (bad_cfg_o[i])
    );
  end

  cswd_match #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_match (
    .win_i    (win),
    .addr_i   (addr_i),
    .sel_o    (sel_d),
    .offset_o (off_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o     <= '0;
      hit_o    <= 1'b0;
      offset_o <= '0;
    end else begin
      cs_o     <= req_i ? sel_d : '0;
      hit_o    <= req_i && (sel_d != '0);
      offset_o <= req_i ? off_d : '0;
    end
  end

  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  a_r11_hit_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (cs_o != '0));
  a_r8_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!hit_o && cs_o == '0 && offset_o == '0));
  a_r2_r3_no_bad_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ((cs_o & $past(bad_cfg_o)) == '0));
endmodule

// File: tb/cs_window_decoder_bench.sv
`timescale 1ns/1ps
module cs_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [11:0] cfg_wdata = '0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  cs;
  logic        hit;
  logic [31:0] offset;
  logic [7:0]  bad;

  int checks = 0;
  int errors = 0;
  logic [11:0] cfg_m [8];

  always #2 clk = ~clk;

  cs_window_decoder u_cs_window_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .req_i(req), .addr_i(addr),
    .cs_o(cs), .hit_o(hit), .offset_o(offset), .bad_cfg_o(bad));

  function automatic logic legal_f(input logic [11:0] c);
    logic [3:0] m = c[11:8];
    return (m == 4'h8 || m == 4'hC || m == 4'hE || m == 4'hF) &&
           ((c[3:0] & ~m) == 4'h0);
  endfunction

  function automatic logic [7:0] exp_bad();
    logic [7:0] b = '0;
    for (int i = 0; i < 8; i++) b[i] = cfg_m[i][6] && !legal_f(cfg_m[i]);
    return b;
  endfunction

  task automatic exp_dec(input logic [31:0] a, output logic [7:0] c, output logic [31:0] o);
    c = '0; o = '0;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] m = cfg_m[i][11:8];
      if (c == '0 && cfg_m[i][6] && legal_f(cfg_m[i]) &&
          a[31:28] == {2'b00, cfg_m[i][5:4]} && (a[27:24] & m) == cfg_m[i][3:0]) begin
        c[i] = 1'b1;
        o = a & {4'h0, ~m, 24'hFFFFFF};
      end
    end
  endtask

  task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [11:0] d, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    cfg_m[s] = d & 12'hF7F;
    @(negedge clk);
    cfg_we = 1'b0;
    chk({tag, " bad_cfg"}, 64'(bad), 64'(exp_bad()));
  endtask

  task automatic rq(input logic [31:0] a, input string tag);
    logic [7:0] ec; logic [31:0] eo;
    exp_dec(a, ec, eo);
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " cs"}, 64'(cs), 64'(ec));
    chk({tag, " hit"}, 64'(hit), 64'(ec != '0));
    chk({tag, " offset"}, 64'(offset), 64'(eo));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 8; i++) cfg_m[i] = '0;
    cfg_m[0] = 12'hF40;
    #9 rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset cs", 64'(cs), 0);
    chk("R5 reset hit", 64'(hit), 0);
    chk("R5 reset bad", 64'(bad), 0);
    rq(32'h0012_3456, "R5 cs0 default");
    chk("R5 cs0 sel", 64'(cs), 64'h1);
    rq(32'h0100_0000, "R5 beyond 16MB");
    // R8: output lasts one cycle only
    @(negedge clk);
    chk("R8 pulse ended", 64'({hit, cs}), 0);
    // R4 R9: 128MB window at 0x08000000
    wr(3'd1, 12'h848, "R4 cs1");
    rq(32'h0ABC_DEF0, "R4 R9 in 128MB");
    chk("R9 offset value", 64'(offset), 64'h02BC_DEF0);
    rq(32'h1000_0000, "R4 above 128MB");
    // R2: illegal mask
    wr(3'd2, 12'hA50, "R2 cs2 mask A");
    chk("R2 flag", 64'(bad[2]), 1);
    rq(32'h1000_0000, "R2 no select");
    // R3: misaligned base
    wr(3'd3, 12'hC46, "R3 cs3 misaligned");
    chk("R3 flag", 64'(bad[3]), 1);
    rq(32'h0600_0000, "R3 no select");
    // R10: flag clears when disabled
    wr(3'd3, 12'hC06, "R10 cs3 disabled");
    chk("R10 flag low", 64'(bad[3]), 0);
    // R7: overlap, lowest wins
    wr(3'd4, 12'hF40, "R7 cs4 overlap");
    rq(32'h0000_1000, "R7 priority");
    chk("R7 cs0 wins", 64'(cs), 64'h01);
    // R6: disable cs0, cs4 takes over
    wr(3'd0, 12'h000, "R6 cs0 off");
    rq(32'h0000_1000, "R6 redecode");
    chk("R6 cs4 now", 64'(cs), 64'h10);
    // R6: move cs1 elsewhere, old range gone
    wr(3'd1, 12'hE52, "R6 cs1 moved");
    rq(32'h0ABC_DEF0, "R6 old window gone");
    rq(32'h13FF_FFFF, "R6 new 32MB window");
    // R1: bit 7 ignored
    wr(3'd5, 12'hFE1, "R1 cs5 bit7");
    rq(32'h2155_AA55, "R1 bit7 ignored");
    chk("R1 cs5 sel", 64'(cs), 64'h20);
    // R4: 64MB window
    wr(3'd6, 12'hC6C, "R4 cs6 64MB");
    rq(32'h2FFF_FFFF, "R4 64MB top");
    rq(32'h3000_0000, "R4 64MB past");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 99);
      if (k < 20) begin
        logic [11:0] d = 12'($urandom);
        if ($urandom_range(0, 1) == 1) begin
          logic [3:0] m;
          case ($urandom_range(0, 3))
            0: m = 4'h8; 1: m = 4'hC; 2: m = 4'hE; default: m = 4'hF;
          endcase
          d[11:8] = m; d[3:0] = d[3:0] & m;
        end
        wr(3'($urandom_range(0, 7)), d, "R2 R3 R10 random cfg");
      end else begin
        logic [31:0] a = $urandom;
        if (k < 80) a[31:24] = {2'b00, cfg_m[$urandom_range(0, 7)][5:0]};
        if (k < 30) begin
          @(negedge clk);
          addr = a;
          @(negedge clk);
          chk("R8 no req cs", 64'({hit, cs}), 0);
          chk("R8 no req offset", 64'(offset), 0);
        end else rq(a, "R4 R7 R9 R11 random req");
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule